// File: doc/BRIEF.md
# Limit-Compare Timer with Watchdog Reset

This block is a free-running up-counter behind a small register bus. Software loads a start value into the count register, a terminal value into the limit register and three option bits into the control register. On each enabled clock the count advances by one. When an advance would make the count equal to the limit, the count returns to zero instead and a limit event is declared.

A limit event sets a sticky pending flag. It drives the interrupt output while interrupts are enabled. If the watchdog option is on, the event also produces a one-cycle reset pulse two clocks later. An optional mode freezes the counter while the processor reports that it is halted.

The bus is a single-cycle register port. Writes take effect at the clock edge in which select and write are high. Read data is combinational from the offset.

Top module: `limit_wdog_timer`

## Requirements
- R1: While reset is asserted, every register reads 0x00000000, and `irq_o` and `wdog_rst_o` are low.
- R2: Writing byte offset 0x0 loads the count, and reading offset 0x0 returns the current count. A count write in the same cycle as an enabled advance wins, and that cycle cannot declare a limit event.
- R3: Offset 0x8 holds the 32-bit limit, which is readable and writable. When an enabled advance would make the count equal to the limit, the count becomes 0 and a limit event is declared. With a limit of 0, the event occurs on the advance from 0xFFFFFFFF.
- R4: Offset 0x4 holds the control bits: bit 2 is interrupt enable, bit 1 is halt gating and bit 0 is watchdog enable. Control bits 31:3 read as zero and ignore writes. Any offset other than 0x0, 0x4 and 0x8 reads zero.
- R5: With control bit 1 set, the count does not advance in cycles where `halt_i` is high. With control bit 1 clear, the count advances on every clock whatever the level of `halt_i`.
- R6: A limit event sets a pending flag that stays set until it is cleared. `irq_o` equals the pending flag AND control bit 2.
- R7: A control write with bit 2 set clears the pending flag. A limit event in the same cycle takes precedence and leaves the flag set.
- R8: `wdog_rst_o` is high in the second cycle after each cycle that declares a limit event while control bit 0 is set. A single event gives a pulse one cycle long. `wdog_rst_o` stays low when bit 0 was clear at the time of the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| halt_i | input | 1 | Processor halted indication |
| irq_o | output | 1 | Level interrupt |
| wdog_rst_o | output | 1 | Watchdog system-reset pulse |

## Verification
Two situations are hard to reach from the ports. The first is a limit event that coincides with a control write. The second is the set of back-to-back events that occur when the limit is 1, which keep the watchdog output high over several cycles. The bench sweeps every control value against several small limits with a start count of zero, under a halt pattern that shifts with each control value. Because of this, halted and running cycles, event cycles and control rewrites overlap in many different alignments. A cycle-by-cycle arithmetic model in the bench supplies the expected count, interrupt and watchdog level after every clock. Directed cases then add the wrap from 0xFFFFFFFF with a limit of 0 and a count write that lands on the cycle that would otherwise declare the event.

// File: rtl/lwt_pkg.sv
`timescale 1ns/1ps
package lwt_pkg;
   // byte offsets of the register window
   localparam int OFF_COUNT = 0;
   localparam int OFF_CTRL  = 4;
   localparam int OFF_LIMIT = 8;
   // control bit positions
   localparam int CB_WD = 0;
   localparam int CB_NH = 1;
   localparam int CB_IE = 2;
   localparam int CTRL_BITS = 3;

   typedef struct packed {
      logic ie;   // interrupt enable
      logic nh;   // count only while not halted
      logic wd;   // watchdog enable
   } ctrl_t;
endpackage

// File: rtl/lwt_delay.sv
`timescale 1ns/1ps
module lwt_delay #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 1) begin : g_bad
         $error("lwt_delay: DEPTH must be at least 1");
      end
      if (DEPTH == 1) begin : g_one
         logic stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= 1'b0;
            else        stg_q <= d;
         end
         assign q = stg_q;
      end else begin : g_many
         logic [DEPTH-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[DEPTH-2:0], d};
         end
         assign q = sr_q[DEPTH-1];

         // R8: the first stage captures each request
         p_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
            d |=> sr_q[0]);
      end
   endgenerate
endmodule

// File: rtl/lwt_counter.sv
`timescale 1ns/1ps
module lwt_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              inc_en,
   input  logic [DATA_W-1:0] limit,
   output logic [DATA_W-1:0] count_q,
   output logic              hit
);
   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W-1:0] cnt_plus;

   assign cnt_plus = count_q + ONE;
   // a load cycle never declares the limit event
   assign hit = inc_en && !load && (cnt_plus == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (load)   count_q <= load_val;
      else if (inc_en) count_q <= hit ? '0 : cnt_plus;
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count_q == $past(load_val));
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> count_q == '0);
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !load && !hit) |=> count_q == $past(count_q) + ONE);
endmodule

// File: rtl/lwt_regs.sv
`timescale 1ns/1ps
module lwt_regs
   import lwt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] count_q,
   input  logic              hit,
   output logic              cnt_load,
   output ctrl_t             ctrl_q,
   output logic [DATA_W-1:0] limit_q,
   output logic              pend_q
);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_COUNT);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(OFF_LIMIT);

   logic wr_any, wr_ctl, wr_lim, clr_pend;

   assign wr_any   = bus_sel && bus_wr;
   assign cnt_load = wr_any && (bus_addr == A_CNT);
   assign wr_ctl   = wr_any && (bus_addr == A_CTL);
   assign wr_lim   = wr_any && (bus_addr == A_LIM);
   assign clr_pend = wr_ctl && bus_wdata[CB_IE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         limit_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctrl_q.ie <= bus_wdata[CB_IE];
            ctrl_q.nh <= bus_wdata[CB_NH];
            ctrl_q.wd <= bus_wdata[CB_WD];
         end
         if (wr_lim) limit_q <= bus_wdata;
         // a new event outranks a clear in the same cycle
         if (hit)           pend_q <= 1'b1;
         else if (clr_pend) pend_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            A_CNT:   bus_rdata = count_q;
            A_CTL:   bus_rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_q};
            A_LIM:   bus_rdata = limit_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr_pend) |=> pend_q);
   p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> pend_q);
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend && !hit) |=> !pend_q);
endmodule

// File: rtl/limit_wdog_timer.sv
`timescale 1ns/1ps
module limit_wdog_timer
   import lwt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int WDOG_DLY = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              halt_i,
   output logic              irq_o,
   output logic              wdog_rst_o
);
   generate
      if (DATA_W < CTRL_BITS + 1) begin : g_chk_w
         $error("limit_wdog_timer: DATA_W too small for control bits");
      end
      if ((1 << ADDR_W) <= OFF_LIMIT) begin : g_chk_a
         $error("limit_wdog_timer: ADDR_W cannot reach the limit offset");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] count_q, limit_q;
   logic              cnt_load, hit, inc_en, pend_q;

   assign inc_en = !(ctrl_q.nh && halt_i);

   lwt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .count_q  (count_q),
      .hit      (hit),
      .cnt_load (cnt_load),
      .ctrl_q   (ctrl_q),
      .limit_q  (limit_q),
      .pend_q   (pend_q)
   );

   lwt_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_load),
      .load_val(bus_wdata),
      .inc_en  (inc_en),
      .limit   (limit_q),
      .count_q (count_q),
      .hit     (hit)
   );

   lwt_delay #(.DEPTH(WDOG_DLY)) u_wdog (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (hit && ctrl_q.wd),
      .q    (wdog_rst_o)
   );

   assign irq_o = pend_q && ctrl_q.ie;

   // R5: a gated, halted cycle without a load leaves the count alone
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.nh && halt_i && !cnt_load) |=> $stable(count_q));

   generate
      if (WDOG_DLY == 2) begin : g_wd_chk
         p_wdog_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && ctrl_q.wd) |-> ##2 wdog_rst_o);
      end
   endgenerate
endmodule

// File: tb/limit_wdog_timer_bench.sv
`timescale 1ns/1ps
module limit_wdog_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, halt = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, wdog;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_cnt = '0, m_lim = '0;
   logic [2:0]  m_ctl = '0;
   logic        m_pend = 1'b0, m_wd1 = 1'b0, m_wd2 = 1'b0;

   always #2.5 clk = ~clk;

   limit_wdog_timer u_limit_wdog_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .halt_i(halt),
      .irq_o(irq), .wdog_rst_o(wdog)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock with the given bus and halt values, then compare with the model
   task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic h, input string tag);
      logic inc, ld, hit;
      logic [31:0] n_cnt, n_lim;
      logic [2:0]  n_ctl;
      logic        n_pend, n_wd1;
      sel = 1'b1; wr = w; addr = a; wdata = d; halt = h;
      inc   = !(m_ctl[1] && h);
      ld    = w && (a == 4'h0);
      hit   = inc && !ld && (m_cnt + 32'd1 == m_lim);
      n_cnt = ld ? d : (inc ? (hit ? 32'd0 : m_cnt + 32'd1) : m_cnt);
      n_ctl = (w && a == 4'h4) ? d[2:0] : m_ctl;
      n_lim = (w && a == 4'h8) ? d : m_lim;
      n_pend = hit ? 1'b1 : ((w && a == 4'h4 && d[2]) ? 1'b0 : m_pend);
      n_wd1 = hit && m_ctl[0];
      @(posedge clk);
      m_wd2 = m_wd1; m_wd1 = n_wd1;
      m_cnt = n_cnt; m_ctl = n_ctl; m_lim = n_lim; m_pend = n_pend;
      @(negedge clk);
      wr = 1'b0; addr = 4'h0;
      #1;
      chk(rdata, m_cnt, tag);
      chk({31'd0, irq}, {31'd0, m_pend && m_ctl[2]}, "R6 irq level");
      chk({31'd0, wdog}, {31'd0, m_wd2}, "R8 watchdog pulse");
   endtask

   // combinational read inside the low phase, no clock passes
   task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #0.2;
      chk(rdata, exp, tag);
      addr = 4'h0;
   endtask

   task automatic idle(input int n, input logic h, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b0, 4'h0, 32'd0, h, tag);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      sel = 1'b1;
      peek(4'h0, 32'd0, "R1 count at reset");
      peek(4'h4, 32'd0, "R1 control at reset");
      peek(4'h8, 32'd0, "R1 limit at reset");
      chk({31'd0, irq},  32'd0, "R1 irq at reset");
      chk({31'd0, wdog}, 32'd0, "R1 wdog at reset");
      rst_n = 1'b1;

      // R4: reserved bits, unmapped and unaligned offsets
      cyc(1'b1, 4'h4, 32'hFFFF_FFF8, 1'b0, "R4 count after ctrl write");
      peek(4'h4, 32'd0, "R4 reserved bits read zero");
      cyc(1'b1, 4'h4, 32'hFFFF_FFFB, 1'b0, "R4 count after ctrl write");
      peek(4'h4, 32'd3, "R4 control keeps only bits 2:0");
      peek(4'hC, 32'd0, "R4 offset 0xC reads zero");
      peek(4'h1, 32'd0, "R4 offset 0x1 reads zero");
      cyc(1'b1, 4'h8, 32'h1234_5678, 1'b1, "R5 count with halt");
      peek(4'h8, 32'h1234_5678, "R3 limit readback");
      cyc(1'b1, 4'h4, 32'd0, 1'b0, "R2 count");

      // sweep: every control value against small limits, shifting halt pattern
      for (int c = 0; c < 8; c++) begin
         for (int lim = 1; lim <= 5; lim++) begin
            cyc(1'b1, 4'h4, 32'(c), 1'b0, "R5 count during setup");
            cyc(1'b1, 4'h8, 32'(lim), 1'b0, "R3 count during setup");
            cyc(1'b1, 4'h0, 32'd0, 1'b1, "R2 count load");
            for (int k = 0; k < 3 * lim + 4; k++)
               cyc(1'b0, 4'h0, 32'd0, ((k + c) % 3) == 0, "R5 R3 count sweep");
         end
      end

      // R6/R7: sticky pending, masking and clear
      cyc(1'b1, 4'h4, 32'd4, 1'b0, "R7 count");
      cyc(1'b1, 4'h8, 32'd3, 1'b0, "R3 count");
      cyc(1'b1, 4'h0, 32'd0, 1'b0, "R2 count");
      idle(6, 1'b0, "R6 count");
      cyc(1'b1, 4'h8, 32'd100, 1'b0, "R6 count");
      idle(4, 1'b0, "R6 pending holds");
      cyc(1'b1, 4'h4, 32'd0, 1'b0, "R6 masked irq");
      cyc(1'b1, 4'h4, 32'd2, 1'b0, "R7 bit2 clear keeps pending");
      cyc(1'b1, 4'h4, 32'd4, 1'b0, "R7 clear on enable write");
      idle(3, 1'b0, "R7 stays clear");

      // R3/R8: limit zero wraps from all ones, watchdog pulse
      cyc(1'b1, 4'h4, 32'd1, 1'b0, "R8 count");
      cyc(1'b1, 4'h8, 32'd0, 1'b0, "R3 count");
      cyc(1'b1, 4'h0, 32'hFFFF_FFFD, 1'b0, "R2 count load near top");
      idle(6, 1'b0, "R3 wrap at limit zero");

      // R2: a load on the would-be event cycle wins
      cyc(1'b1, 4'h8, 32'd10, 1'b0, "R2 count");
      cyc(1'b1, 4'h0, 32'd8, 1'b0, "R2 count load");
      cyc(1'b1, 4'h0, 32'd9, 1'b0, "R2 load beats advance");
      cyc(1'b1, 4'h0, 32'd9, 1'b0, "R2 load suppresses event");
      idle(4, 1'b0, "R2 event after load");

      // R5: gating off, halt high still counts
      cyc(1'b1, 4'h4, 32'd0, 1'b1, "R5 count");
      idle(5, 1'b1, "R5 ungated counts while halted");

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule